// File: doc/BRIEF.md
# Linear Sector to Cylinder/Head/Sector Command Builder

This block turns a linear sector address into the six-byte command block that a disk controller expects for a read or a write. The drive has a fixed track length of 17 sectors and a head count that is given per request. The block splits the address into cylinder, head and sector, and then sends the command bytes one by one over a byte stream.

A request is a single-cycle `start` pulse. With it come the sector address, the drive select, the direction, the number of sectors to move, the head count and a control byte. A single sequential restoring divider is used twice. The first pass divides the address by (heads × 17) to get the cylinder. The second pass divides the remainder by 17 to get the head and the sector. Once both passes are done, the six bytes go out on `out_valid`/`out_ready`/`out_data`. A byte is taken on any clock edge where `out_valid` and `out_ready` are both high. While `out_ready` is low, the current byte and `out_valid` stay unchanged for as long as the sink stalls. The sink may hold `out_ready` high all the time, or change it on any cycle. `out_last` marks the sixth byte.

If a request has a zero head count, or produces a cylinder that does not fit in ten bits, it is refused. The refusal raises `err` and no byte is sent. `err` stays high until the next accepted request clears it.

Top module: `chs_cmd_builder`

## Requirements
- R1: For head count H (1 to 31) and address A, the command encodes cylinder = A / (17·H), head = (A mod 17·H) / 17 and sector = A mod 17, with sectors counted from zero.
- R2: Byte 0 is the opcode: 0x08 when `op_write` is 0, and 0x0A when `op_write` is 1.
- R3: Byte 1 carries the head number in bits 4:0 and `drive_sel` in bits 6:5. Bit 7 is zero.
- R4: Byte 2 carries cylinder bits 9:8 in bits 7:6 and the sector in bits 4:0. Bit 5 is zero.
- R5: Byte 3 is cylinder bits 7:0, byte 4 is `xfer_count`, and byte 5 is `ctrl_byte`.
- R6: The bytes leave in order 0 to 5, one per valid/ready handshake. `out_last` is high only with byte 5, and `out_valid` falls after byte 5 is taken.
- R7: While `out_valid` is high and `out_ready` is low, `out_data`, `out_last` and `out_valid` do not change.
- R8: A `start` pulse that arrives while `busy` is high is ignored. The bytes sent are those of the request already in progress.
- R9: A cylinder above 1023 sets `err` and no byte is sent.
- R10: A head count of zero sets `err` one clock after the start and no byte is sent.
- R11: After reset, `busy`, `err` and `out_valid` are low.
- R12: An accepted request with a nonzero head count clears `err` on the clock edge that accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, taken only while idle |
| blk_num | input | BLK_W | Linear sector address |
| drive_sel | input | 2 | Drive number |
| op_write | input | 1 | 1 = write, 0 = read |
| xfer_count | input | 8 | Number of sectors to move |
| head_count | input | 5 | Heads per cylinder |
| ctrl_byte | input | 8 | Control byte for this drive |
| busy | output | 1 | High from an accepted start until the last byte is taken |
| err | output | 1 | Request refused (zero heads or cylinder too large) |
| out_valid | output | 1 | Stream byte valid |
| out_ready | input | 1 | Stream sink ready |
| out_data | output | 8 | Stream byte |
| out_last | output | 1 | Marks the sixth byte |

## Verification
A bad divider step shows up in the cylinder, head and sector fields of bytes 1 to 3. The bench checks these fields against addresses chosen to land exactly on the 17-sector and cylinder boundaries. A corrupted byte index in the output stage shows up on the next handshake, either as a byte out of place or as a misplaced `out_last`. A controller state that fails to return to idle, or that accepts a start while busy, is caught in one of three ways: the following request never produces bytes, the bytes of an injected request appear, or `err` does not follow the refusal rules within the request's own window of about fifty cycles.

// File: rtl/chs_pkg.sv
package chs_pkg;

  localparam int SPT      = 17;
  localparam int HEAD_W   = 5;
  localparam int DRV_W    = 2;
  localparam int CYL_W    = 10;
  localparam int SEC_W    = 5;
  localparam int CMD_LEN  = 6;

  localparam logic [7:0] OPC_READ  = 8'h08;
  localparam logic [7:0] OPC_WRITE = 8'h0A;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DIV_CYL,
    ST_DIV_HEAD,
    ST_SEND
  } chs_state_e;

  // byte 0 sits in the low lane, byte 5 in the high lane
  function automatic logic [CMD_LEN*8-1:0] pack_cmd(
    input logic              wr,
    input logic [DRV_W-1:0]  drv,
    input logic [HEAD_W-1:0] head,
    input logic [CYL_W-1:0]  cyl,
    input logic [SEC_W-1:0]  sec,
    input logic [7:0]        cnt,
    input logic [7:0]        ctl
  );
    logic [7:0] b0, b1, b2, b3;
    b0 = wr ? OPC_WRITE : OPC_READ;
    b1 = {1'b0, drv, head};
    b2 = {cyl[9:8], 1'b0, sec};
    b3 = cyl[7:0];
    return {ctl, cnt, b3, b2, b1, b0};
  endfunction

endpackage

// File: rtl/chs_seq_div.sv
module chs_seq_div #(
  parameter int N = 24,
  parameter int D = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [N-1:0] dividend,
  input  logic [D-1:0] divisor,
  output logic         done,
  output logic [N-1:0] quot,
  output logic [D-1:0] rem
);
  localparam int CW = $clog2(N + 1);

  logic [N-1:0]  q_r;
  logic [D-1:0]  r_r;
  logic [D-1:0]  dv_r;
  logic [CW-1:0] cnt_r;
  logic          run_r;
  logic          done_r;
  logic [D:0]    trial;
  logic [D:0]    diff;
  logic          ge;

  always_comb begin
    trial = {r_r, q_r[N-1]};
    ge    = trial >= {1'b0, dv_r};
    diff  = trial - {1'b0, dv_r};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_r    <= '0;
      r_r    <= '0;
      dv_r   <= '0;
      cnt_r  <= '0;
      run_r  <= 1'b0;
      done_r <= 1'b0;
    end else if (start) begin
      q_r    <= dividend;
      r_r    <= '0;
      dv_r   <= divisor;
      cnt_r  <= CW'(N);
      run_r  <= 1'b1;
      done_r <= 1'b0;
    end else if (run_r) begin
      q_r   <= {q_r[N-2:0], ge};
      r_r   <= ge ? diff[D-1:0] : trial[D-1:0];
      cnt_r <= cnt_r - 1'b1;
      if (cnt_r == CW'(1)) begin
        run_r  <= 1'b0;
        done_r <= 1'b1;
      end
    end else begin
      done_r <= 1'b0;
    end
  end

  assign done = done_r;
  assign quot = q_r;
  assign rem  = r_r;

  // R1
  rem_below_divisor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (rem < dv_r));

  // R1
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: rtl/chs_byte_tx.sv
module chs_byte_tx #(
  parameter int NB = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [NB*8-1:0] bytes_in,
  input  logic            out_ready,
  output logic            out_valid,
  output logic [7:0]      out_data,
  output logic            out_last,
  output logic            fin
);
  localparam int IW = $clog2(NB);

  logic [NB*8-1:0] buf_r;
  logic [IW-1:0]   idx_r;
  logic            vld_r;
  logic [7:0]      lane [NB];

  genvar g;
  generate
    for (g = 0; g < NB; g++) begin : g_lane
      assign lane[g] = buf_r[g*8 +: 8];
    end
  endgenerate

  assign out_valid = vld_r;
  assign out_data  = lane[idx_r];
  assign out_last  = vld_r && (idx_r == IW'(NB - 1));
  assign fin       = vld_r && out_ready && out_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_r <= '0;
      idx_r <= '0;
      vld_r <= 1'b0;
    end else if (load) begin
      buf_r <= bytes_in;
      idx_r <= '0;
      vld_r <= 1'b1;
    end else if (vld_r && out_ready) begin
      if (out_last) vld_r <= 1'b0;
      else          idx_r <= idx_r + 1'b1;
    end
  end

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  // R6
  last_has_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  // R6
  drop_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> !out_valid);

endmodule

// File: rtl/chs_cmd_builder.sv
module chs_cmd_builder
  import chs_pkg::*;
#(
  parameter int BLK_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BLK_W-1:0]  blk_num,
  input  logic [1:0]        drive_sel,
  input  logic              op_write,
  input  logic [7:0]        xfer_count,
  input  logic [4:0]        head_count,
  input  logic [7:0]        ctrl_byte,
  output logic              busy,
  output logic              err,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_data,
  output logic              out_last
);
  localparam int DV_W = HEAD_W + 5;   // 31*17 fits in 10 bits

  chs_state_e st_r;

  logic [DRV_W-1:0] drv_r;
  logic             wr_r;
  logic [7:0]       cnt_r;
  logic [7:0]       ctl_r;
  logic [CYL_W-1:0] cyl_r;
  logic             err_r;

  logic             div_start;
  logic [BLK_W-1:0] div_dvd;
  logic [DV_W-1:0]  div_dvs;
  logic             div_done;
  logic [BLK_W-1:0] div_quot;
  logic [DV_W-1:0]  div_rem;
  logic             cyl_ovf;
  logic             tx_load;
  logic             tx_fin;
  logic [CMD_LEN*8-1:0] cmd_bytes;

  assign cyl_ovf = |div_quot[BLK_W-1:CYL_W];

  always_comb begin
    div_start = 1'b0;
    div_dvd   = blk_num;
    div_dvs   = DV_W'(head_count) * DV_W'(SPT);
    case (st_r)
      ST_IDLE:    div_start = start && (head_count != '0);
      ST_DIV_CYL: begin
        div_dvd   = BLK_W'(div_rem);
        div_dvs   = DV_W'(SPT);
        div_start = div_done && !cyl_ovf;
      end
      default: ;
    endcase
  end

  chs_seq_div #(.N(BLK_W), .D(DV_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (div_start),
    .dividend (div_dvd),
    .divisor  (div_dvs),
    .done     (div_done),
    .quot     (div_quot),
    .rem      (div_rem)
  );

  assign tx_load   = (st_r == ST_DIV_HEAD) && div_done;
  assign cmd_bytes = pack_cmd(wr_r, drv_r, div_quot[HEAD_W-1:0], cyl_r,
                              div_rem[SEC_W-1:0], cnt_r, ctl_r);

  chs_byte_tx #(.NB(CMD_LEN)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (tx_load),
    .bytes_in  (cmd_bytes),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_last  (out_last),
    .fin       (tx_fin)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_r  <= ST_IDLE;
      drv_r <= '0;
      wr_r  <= 1'b0;
      cnt_r <= '0;
      ctl_r <= '0;
      cyl_r <= '0;
      err_r <= 1'b0;
    end else begin
      case (st_r)
        ST_IDLE: if (start) begin
          if (head_count == '0) begin
            err_r <= 1'b1;
          end else begin
            err_r <= 1'b0;
            drv_r <= drive_sel;
            wr_r  <= op_write;
            cnt_r <= xfer_count;
            ctl_r <= ctrl_byte;
            st_r  <= ST_DIV_CYL;
          end
        end
        ST_DIV_CYL: if (div_done) begin
          if (cyl_ovf) begin
            err_r <= 1'b1;
            st_r  <= ST_IDLE;
          end else begin
            cyl_r <= div_quot[CYL_W-1:0];
            st_r  <= ST_DIV_HEAD;
          end
        end
        ST_DIV_HEAD: if (div_done) st_r <= ST_SEND;
        ST_SEND:     if (tx_fin)   st_r <= ST_IDLE;
        default:     st_r <= ST_IDLE;
      endcase
    end
  end

  assign busy = (st_r != ST_IDLE);
  assign err  = err_r;

  // R9
  err_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !out_valid);

  // R10
  zero_heads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && (head_count == '0)) |=> (err && !busy));

  // R2
  opcode_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (out_data == OPC_READ || out_data == OPC_WRITE));

  // R12
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && (head_count != '0)) |=> (!err && busy));

endmodule

// File: tb/chs_cmd_builder_test.sv
module chs_cmd_builder_test;
  localparam int BLK_W = 24;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [BLK_W-1:0] blk_num = '0;
  logic [1:0]       drive_sel = '0;
  logic             op_write = 1'b0;
  logic [7:0]       xfer_count = '0;
  logic [4:0]       head_count = '0;
  logic [7:0]       ctrl_byte = '0;
  logic             busy, err, out_valid, out_data_last;
  logic             out_ready = 1'b0;
  logic [7:0]       out_data;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;   // 50 MHz

  chs_cmd_builder #(.BLK_W(BLK_W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .blk_num(blk_num),
    .drive_sel(drive_sel), .op_write(op_write), .xfer_count(xfer_count),
    .head_count(head_count), .ctrl_byte(ctrl_byte), .busy(busy), .err(err),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_data_last)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  task automatic kick(input int unsigned b, input int d, input bit w,
                      input int c, input int h, input int ct);
    @(negedge clk);
    blk_num = BLK_W'(b); drive_sel = 2'(d); op_write = w;
    xfer_count = 8'(c); head_count = 5'(h); ctrl_byte = 8'(ct);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // stall: 0 = always ready, 1 = ready one cycle in three
  // inj: cycle at which a second start is pulsed while busy (-1 = none)
  task automatic run_cmd(input string tag, input int unsigned b, input int d,
                         input bit w, input int c, input int h, input int ct,
                         input int stall, input int inj);
    int unsigned spc, cyl, hd, sec;
    int exp [6];
    int got;
    bit prev_stall;
    int prev_data;
    spc = 17 * h;
    cyl = b / spc;
    hd  = (b % spc) / 17;
    sec = b % 17;
    exp[0] = w ? 8'h0A : 8'h08;
    exp[1] = (d << 5) | hd;
    exp[2] = ((cyl >> 8) << 6) | sec;
    exp[3] = cyl & 8'hFF;
    exp[4] = c;
    exp[5] = ct;
    kick(b, d, w, c, h, ct);
    chk({tag, " R12 err clear"}, int'(err), 0);
    got = 0;
    prev_stall = 0;
    prev_data = 0;
    for (int i = 0; i < 400 && got < 6; i++) begin
      if (i == inj) begin
        blk_num = BLK_W'(b + 5000); op_write = ~w; head_count = 5'(h + 1);
        ctrl_byte = 8'h5A; start = 1'b1;
      end else begin
        start = 1'b0;
      end
      out_ready = (stall == 0) ? 1'b1 : ((i % 3) == 2);
      if (prev_stall) begin
        chk({tag, " R7 hold valid"}, int'(out_valid), 1);
        chk({tag, " R7 hold data"}, int'(out_data), prev_data);
      end
      prev_stall = out_valid && !out_ready;
      prev_data  = int'(out_data);
      if (out_valid && out_ready) begin
        // R1 R2 R3 R4 R5 byte contents, R8 when inj >= 0
        chk($sformatf("%s R6 byte%0d", tag, got), int'(out_data), exp[got]);
        chk($sformatf("%s R6 last%0d", tag, got), int'(out_data_last), int'(got == 5));
        got++;
      end
      @(negedge clk);
    end
    start = 1'b0;
    out_ready = 1'b0;
    chk({tag, " R6 count"}, got, 6);
    chk({tag, " R6 valid drops"}, int'(out_valid), 0);
    @(negedge clk);
    chk({tag, " busy low"}, int'(busy), 0);
  endtask

  task automatic run_reject(input string tag, input int unsigned b, input int h);
    int seen;
    kick(b, 1, 1'b1, 2, h, 8'h11);
    if (h == 0) chk({tag, " R10 err next cycle"}, int'(err), 1);
    seen = 0;
    out_ready = 1'b1;
    for (int i = 0; i < 120; i++) begin
      if (out_valid) seen++;
      @(negedge clk);
    end
    out_ready = 1'b0;
    chk({tag, " R9 R10 no bytes"}, seen, 0);
    chk({tag, " R9 R10 err set"}, int'(err), 1);
    chk({tag, " idle after reject"}, int'(busy), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 busy", int'(busy), 0);
    chk("R11 err", int'(err), 0);
    chk("R11 valid", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 R3: read, 4 heads
    run_cmd("read4", 1000, 1, 1'b0, 3, 4, 8'h05, 0, -1);
    // R4 R5 R7: write, 16 heads, top of cylinder 1023 with stalls
    run_cmd("wr16", 1023*272 + 271, 3, 1'b1, 8'hFF, 16, 8'hC3, 1, -1);
    // R1 R4: single head, last legal address
    run_cmd("edge1", 17407, 2, 1'b0, 1, 1, 8'h00, 0, -1);
    // R9: one past the last cylinder
    run_reject("ovf", 17408, 1);
    // R12: recovery after cylinder overflow
    run_cmd("recov", 16, 0, 1'b1, 7, 2, 8'h80, 1, -1);
    // R10: zero heads
    run_reject("zeroh", 50, 0);
    // R8: second start while busy is ignored
    run_cmd("busy", 123456, 2, 1'b0, 9, 31, 8'h42, 0, 4);
    run_cmd("busy2", 777, 1, 1'b1, 4, 5, 8'h24, 1, 40);
    // R1: address zero, 31 heads
    run_cmd("zero", 0, 0, 1'b0, 1, 31, 8'h01, 0, -1);
    summary();
  end
endmodule